// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Tag-Overflow Trap

This block adds or subtracts two 64-bit operands used as tagged words. The first operand always comes from a register. The second comes either from a register or from a 13-bit immediate that is sign-extended to 64 bits. The unit produces the 64-bit result together with two sets of N/Z/V/C condition flags. The narrow set describes the low 32 bits and the wide set describes all 64 bits.

The narrow overflow flag is a tag overflow. It is set when either operand carries a nonzero tag in its two lowest bits, or when the 32-bit signed result overflows. A mode input selects the trapping variant. In that variant, a tag overflow raises a one-cycle trap and leaves the destination and the flags untouched.

Results are registered. A small state machine records what the previous valid cycle did, and it has three states:
- `ST_IDLE`: no operation.
- `ST_WRITE`: the result and flags were committed.
- `ST_TRAP`: the operation trapped.

On every clock, the next state is chosen as follows:
- `ST_TRAP` when `valid` is high, trapping mode is selected and a tag overflow is present.
- `ST_WRITE` when `valid` is high otherwise.
- `ST_IDLE` when `valid` is low.

Any state can move to any of the three. The `wr_en` and `trap` outputs decode this state.

Top module: `tagalu`

## Requirements
- R1: After reset, `wr_en` and `trap` are 0, `result` is 0 and both flag sets are 0.
- R2: One clock after a `valid` cycle that commits, `result` equals op_a + B when `is_sub`=0 and op_a - B (mod 2^64) when `is_sub`=1. B is `op_b` when `use_imm`=0 and the sign-extended `imm` when `use_imm`=1.
- R3: Narrow C (`icc[0]`) is the carry out of bit 31 of the low-half sum for add. For subtract it is the borrow, i.e. 1 when op_a[31:0] < B[31:0] unsigned.
- R4: Wide flags `xcc` = {N,Z,V,C} at bits {3,2,1,0}:
  - N is result bit 63.
  - Z is 1 when all 64 bits are 0.
  - V is 64-bit signed overflow.
  - C is the carry out of bit 63 for add, or the borrow (op_a < B unsigned) for subtract.
- R5: Narrow V (`icc[1]`) is 1 whenever op_a[1:0] or B[1:0] is nonzero.
- R6: Narrow V is also 1 when the 32-bit signed add or subtract of the low halves overflows.
- R7: Narrow N (`icc[3]`) is result bit 31, and narrow Z (`icc[2]`) is 1 when result bits 31:0 are all 0.
- R8: With `trap_mode`=0, a `valid` cycle always commits: `wr_en` pulses for one cycle and the result and flags update, even on tag overflow.
- R9: With `trap_mode`=1 and a tag overflow, `trap` pulses for one cycle, `wr_en` stays 0, and `result`, `icc` and `xcc` keep their previous values.
- R10: A cycle with `valid`=0 gives `wr_en`=0 and `trap`=0 one clock later, and leaves `result` and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation strobe |
| is_sub | input | 1 | 1 = subtract, 0 = add |
| trap_mode | input | 1 | 1 = trapping variant |
| use_imm | input | 1 | 1 = second operand from immediate |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second register operand |
| imm | input | 13 | Signed immediate |
| result | output | 64 | Registered result |
| icc | output | 4 | Narrow flags {N,Z,V,C} |
| xcc | output | 4 | Wide flags {N,Z,V,C} |
| wr_en | output | 1 | Destination write pulse |
| trap | output | 1 | Tag-overflow trap pulse |

## Verification
Every output of an operation is due exactly one rising edge after the edge that samples `valid`. This holds for the result, both flag sets, and the `wr_en` and `trap` pulses. The bench changes inputs on the falling edge, lets a single rising edge pass, and compares all outputs on the following falling edge. No result is read earlier or later than that. Held values after traps and idle cycles are compared against the last committed values that the bench itself tracks.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_TRAP  = 2'd2
    } tag_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;
endpackage

// File: rtl/tagalu_opsel.sv
module tagalu_opsel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 13
) (
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              is_sub,
    output logic [DATA_W-1:0] b_sel,
    output logic [DATA_W-1:0] b_eff,
    output logic              cin
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        b_sel   = use_imm ? imm_ext : op_b;
        b_eff   = is_sub ? ~b_sel : b_sel;
        cin     = is_sub;
    end
endmodule

// File: rtl/tagalu_core.sv
module tagalu_core
    import tagalu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int TAG_W    = 2
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] b_sel,
    input  logic [DATA_W-1:0] b_eff,
    input  logic              cin,
    input  logic              is_sub,
    output logic [DATA_W-1:0] sum,
    output cc_t               cc_n,
    output cc_t               cc_w,
    output logic              tag_ov
);
    localparam int NMSB = NARROW_W - 1;
    localparam int WMSB = DATA_W - 1;

    logic [DATA_W:0] full;
    logic            carry_n;
    logic            ovf_n;
    logic            ovf_w;
    logic            tag_bits;

    always_comb begin
        full     = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        sum      = full[DATA_W-1:0];
        // carry into bit NARROW_W recovered from the sum bit there
        carry_n  = op_a[NARROW_W] ^ b_eff[NARROW_W] ^ full[NARROW_W];
        ovf_n    = (op_a[NMSB] == b_eff[NMSB]) && (full[NMSB] != op_a[NMSB]);
        ovf_w    = (op_a[WMSB] == b_eff[WMSB]) && (full[WMSB] != op_a[WMSB]);
        tag_bits = (|op_a[TAG_W-1:0]) | (|b_sel[TAG_W-1:0]);
        tag_ov   = tag_bits | ovf_n;

        cc_n.n = full[NMSB];
        cc_n.z = ~|full[NMSB:0];
        cc_n.v = tag_ov;
        cc_n.c = carry_n ^ is_sub;

        cc_w.n = full[WMSB];
        cc_w.z = ~|full[WMSB:0];
        cc_w.v = ovf_w;
        cc_w.c = full[DATA_W] ^ is_sub;
    end
endmodule

// File: rtl/tagalu.sv
module tagalu
    import tagalu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 13,
    parameter int TAG_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              is_sub,
    input  logic              trap_mode,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        icc,
    output logic [3:0]        xcc,
    output logic              wr_en,
    output logic              trap
);
    tag_state_e        state_q, state_d;
    logic [DATA_W-1:0] b_sel, b_eff, sum;
    logic              cin, tag_ov;
    cc_t               cc_n, cc_w, icc_q, xcc_q;
    logic [DATA_W-1:0] res_q;

    tagalu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .op_b    (op_b),
        .imm     (imm),
        .use_imm (use_imm),
        .is_sub  (is_sub),
        .b_sel   (b_sel),
        .b_eff   (b_eff),
        .cin     (cin)
    );

    tagalu_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .TAG_W(TAG_W)) u_core (
        .op_a    (op_a),
        .b_sel   (b_sel),
        .b_eff   (b_eff),
        .cin     (cin),
        .is_sub  (is_sub),
        .sum     (sum),
        .cc_n    (cc_n),
        .cc_w    (cc_w),
        .tag_ov  (tag_ov)
    );

    always_comb begin
        if (!valid)
            state_d = ST_IDLE;
        else if (trap_mode && tag_ov)
            state_d = ST_TRAP;
        else
            state_d = ST_WRITE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            icc_q   <= '0;
            xcc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_WRITE) begin
                res_q <= sum;
                icc_q <= cc_n;
                xcc_q <= cc_w;
            end
        end
    end

    always_comb begin
        wr_en  = 1'b0;
        trap   = 1'b0;
        result = res_q;
        icc    = icc_q;
        xcc    = xcc_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: wr_en = 1'b1;
            ST_TRAP:  trap  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/tagalu_chk.sv
module tagalu_chk #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic              trap_mode,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        icc,
    input logic [3:0]        xcc,
    input logic              wr_en,
    input logic              trap
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && trap)); // R9
    AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (wr_en || trap) |-> $past(valid)); // R10
    AST_TRAP_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n) trap |-> $past(trap_mode)); // R9
    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) trap |-> ($stable(result) && $stable(icc) && $stable(xcc))); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!wr_en && !trap) |-> ($stable(result) && $stable(icc))); // R10
    AST_TAG_SETS_V: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && ($past(op_a[TAG_W-1:0]) != '0)) |-> icc[1]); // R5
    AST_NO_TRAP_WITHOUT_MODE: assert property (@(posedge clk) disable iff (!rst_n) ($past(valid) && !$past(trap_mode)) |-> wr_en); // R8
    AST_WIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && result == '0) |-> xcc[2]); // R4
endmodule

bind tagalu tagalu_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid),
    .trap_mode (trap_mode),
    .op_a      (op_a),
    .result    (result),
    .icc       (icc),
    .xcc       (xcc),
    .wr_en     (wr_en),
    .trap      (trap)
);

// File: tb/tagalu_test.sv
module tagalu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, is_sub = 1'b0, trap_mode = 1'b0, use_imm = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [12:0] imm = '0;
    logic [63:0] result;
    logic [3:0]  icc, xcc;
    logic        wr_en, trap;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [63:0] m_res = '0;
    logic [3:0]  m_icc = '0, m_xcc = '0;

    tagalu uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .is_sub(is_sub),
        .trap_mode(trap_mode), .use_imm(use_imm), .op_a(op_a), .op_b(op_b),
        .imm(imm), .result(result), .icc(icc), .xcc(xcc),
        .wr_en(wr_en), .trap(trap)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic sub, input logic tm, input logic ui,
                          input logic [63:0] a, input logic [63:0] b, input logic [12:0] im);
        logic [63:0] bb;
        logic [64:0] w;
        logic [32:0] nw;
        logic signed [32:0] s32;
        logic signed [64:0] s64;
        logic        v32, tov, cn, cw, vw;
        logic [3:0]  e_icc, e_xcc;
        bb = ui ? {{51{im[12]}}, im} : b;
        if (sub) begin
            w   = {1'b0, a} - {1'b0, bb};
            cn  = (a[31:0] < bb[31:0]);
            cw  = (a < bb);
            s32 = $signed({a[31], a[31:0]}) - $signed({bb[31], bb[31:0]});
            s64 = $signed({a[63], a}) - $signed({bb[63], bb});
        end else begin
            w   = {1'b0, a} + {1'b0, bb};
            nw  = {1'b0, a[31:0]} + {1'b0, bb[31:0]};
            cn  = nw[32];
            cw  = w[64];
            s32 = $signed({a[31], a[31:0]}) + $signed({bb[31], bb[31:0]});
            s64 = $signed({a[63], a}) + $signed({bb[63], bb});
        end
        v32 = (s32[32] != s32[31]);
        vw  = (s64[64] != s64[63]);
        tov = (a[1:0] != 2'b00) || (bb[1:0] != 2'b00) || v32;
        e_icc = {w[31], (w[31:0] == 32'd0), tov, cn};
        e_xcc = {w[63], (w[63:0] == 64'd0), vw, cw};

        @(negedge clk);
        valid = 1'b1; is_sub = sub; trap_mode = tm; use_imm = ui;
        op_a = a; op_b = b; imm = im;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        if (tm && tov) begin
            chk("R9 trap", trap, 1);
            chk("R9 wr_en", wr_en, 0);
            chk("R9 result held", result, m_res);
            chk("R9 icc held", icc, m_icc);
            chk("R9 xcc held", xcc, m_xcc);
        end else begin
            m_res = w[63:0]; m_icc = e_icc; m_xcc = e_xcc;
            chk("R8 wr_en", wr_en, 1);
            chk("R8 trap", trap, 0);
            chk("R2 result", result, m_res);
            chk("R3 icc C", icc[0], e_icc[0]);
            if (a[1:0] != 0 || bb[1:0] != 0) chk("R5 icc V tag", icc[1], 1);
            else                             chk("R6 icc V ovf", icc[1], e_icc[1]);
            chk("R7 icc N/Z", icc[3:2], e_icc[3:2]);
            chk("R4 xcc", xcc, e_xcc);
        end
    endtask

    initial begin
        logic [63:0] vals [12];
        logic [12:0] imms [5];
        vals = '{64'h0, 64'h1, 64'h2, 64'h3, 64'h4, 64'h7FFF_FFFC,
                 64'h8000_0000, 64'hFFFF_FFFC, 64'h7FFF_FFFF_FFFF_FFFC,
                 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFC,
                 64'h0000_0001_0000_0000};
        imms = '{13'h0000, 13'h0004, 13'h0001, 13'h1000, 13'h1FFC};
        repeat (3) @(negedge clk);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 trap", trap, 0);
        chk("R1 result", result, 0);
        chk("R1 flags", {icc, xcc}, 0);
        rst_n = 1'b1;
        for (int tm = 0; tm < 2; tm++)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 12; j++)
                        run_op(s[0], tm[0], 1'b0, vals[i], vals[j], 13'h0);
                    for (int k = 0; k < 5; k++)
                        run_op(s[0], tm[0], 1'b1, vals[i], 64'hFFFF_0000_0000_0000, imms[k]);
                end
        // idle cycles after a commit: nothing changes
        run_op(1'b0, 1'b0, 1'b0, 64'h10, 64'h20, 13'h0);
        for (int c = 0; c < 3; c++) begin
            op_a = 64'h5; op_b = 64'h9; is_sub = c[0];
            @(posedge clk);
            @(negedge clk);
            chk("R10 wr_en", wr_en, 0);
            chk("R10 trap", trap, 0);
            chk("R10 result", result, 64'h30);
            chk("R10 flags", {icc, xcc}, {m_icc, m_xcc});
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule